// File: doc/BRIEF.md
# AES-128 Round-Constant Generator and Round Counter

This block supplies the byte constants that the AES-128 key expansion folds into the first byte of each new key word. It also serves as the cipher controller's round counter. A single 8-bit shift register with Galois feedback holds the current constant.

Each enabled step either multiplies the register by x in GF(2^8) or divides it by x. Multiplying walks the constants in encryption and forward key-expansion order. Dividing walks them in the order needed for reverse key scheduling during decryption.

The round counter is the constant value itself, so no separate counter exists. When the controller reports that a round is complete while the register holds the final value for the chosen direction, a sticky ready flag is raised and the register freezes. Both stay that way until the next reset.

The key datapath reads the constant through a gated byte. This byte carries the constant only while the first byte of a word is being processed, and zero otherwise.

Top module: `rcon_counter`

## Requirements
- R1: A cycle with `rst` high and `dir_back` low loads the constant 0x01 and clears `ready`. Both are visible after that clock edge.
- R2: A cycle with `rst` high and `dir_back` high loads the constant 0x36 and clears `ready`.
- R3: With `dir_back` low, each clock edge with `step` high and `ready` low multiplies the constant by x modulo x^8+x^4+x^3+x+1. From 0x01 this produces 01,02,04,08,10,20,40,80,1B,36, and one step past 0x36 gives 0x6C.
- R4: With `dir_back` high, each enabled step divides the constant by x. If bit 0 is set, the value is xored with 0x1B, shifted right, and bit 7 is set; otherwise it is only shifted right. From 0x36 this walks the R3 list backwards, and one step past 0x01 gives 0x8D.
- R5: A clock edge with `step` low leaves the constant unchanged.
- R6: `key_rc` equals the constant while `lead_byte` is 1 and is 0x00 while `lead_byte` is 0.
- R7: `ready` rises at the edge that samples `round_done` high while the constant is the final value for the direction: 0x36 forward, 0x01 backward. `round_done` at any other value has no effect.
- R8: Once `ready` is set, `step` and `round_done` are ignored. The constant holds and `ready` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; direction sampled with it |
| dir_back | input | 1 | 0 = forward (multiply by x), 1 = backward (divide by x) |
| step | input | 1 | Advance the constant by one position |
| round_done | input | 1 | Strobe: the current round has finished |
| lead_byte | input | 1 | High while the key datapath handles the first byte of a word |
| rc | output | 8 | Current round constant |
| key_rc | output | 8 | Constant gated by `lead_byte`, zero otherwise |
| ready | output | 1 | Sticky flag: the last round has completed |

## Verification
The constant and `ready` are registered, so a change caused by `step`, `round_done` or `rst` is due one clock edge after the inputs are applied. `key_rc` is combinational and follows `lead_byte` within the same cycle.

The driver applies inputs on the falling edge. For each cycle it queues the values expected after the next rising edge, and the monitor compares them one time unit after that rising edge, while the inputs are still held. Each comparison therefore sees the new registered state together with the gating input that produced it.

The expected constants come from a table indexed by a model position, not from a field computation. This table covers both ends of each walk, including one step past each end.

// File: rtl/rcon_counter.sv
module rcon_counter #(
  parameter int W = 8,
  parameter logic [W-1:0] POLY_LO = 8'h1B,
  parameter logic [W-1:0] FWD_SEED = 8'h01,
  parameter logic [W-1:0] BWD_SEED = 8'h36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_back,
  input  logic         step,
  input  logic         round_done,
  input  logic         lead_byte,
  output logic [W-1:0] rc,
  output logic [W-1:0] key_rc,
  output logic         ready
);

  localparam logic [W-1:0] FWD_LAST = BWD_SEED;
  localparam logic [W-1:0] BWD_LAST = FWD_SEED;

  function automatic logic [W-1:0] mul_x(input logic [W-1:0] v);
    return {v[W-2:0], 1'b0} ^ (v[W-1] ? POLY_LO : '0);
  endfunction

  function automatic logic [W-1:0] div_x(input logic [W-1:0] v);
    logic [W-1:0] t;
    t = v[0] ? (v ^ POLY_LO) : v;
    return {v[0], t[W-1:1]};
  endfunction

  logic [W-1:0] rc_q;
  logic         rdy_q;
  logic         at_last;

  assign at_last = dir_back ? (rc_q == BWD_LAST) : (rc_q == FWD_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_q  <= dir_back ? BWD_SEED : FWD_SEED;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (round_done && at_last) rdy_q <= 1'b1;
      if (step) rc_q <= dir_back ? div_x(rc_q) : mul_x(rc_q);
    end
  end

  assign rc     = rc_q;
  assign ready  = rdy_q;
  assign key_rc = lead_byte ? rc_q : '0;

  a_r3_fwd_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(step) && !$past(rdy_q) && !$past(dir_back))
      |-> div_x(rc_q) == $past(rc_q));

  a_r4_bwd_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(step) && !$past(rdy_q) && $past(dir_back))
      |-> mul_x(rc_q) == $past(rc_q));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(rc_q));

  a_r7_rise_cause: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(rdy_q)) |-> $past(round_done));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    rdy_q |=> (rdy_q && $stable(rc_q)));

  a_r6_gate: assert property (@(posedge clk) disable iff (rst)
    (key_rc == '0) || (key_rc == rc_q));

endmodule

// File: tb/tb_rcon_counter.sv
module tb_rcon_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 5000;

  typedef struct {
    logic [7:0] rc;
    logic [7:0] key;
    logic       rdy;
    string      tag;
  } exp_t;

  logic clk = 0, rst = 1, dir_back = 0, step = 0, round_done = 0, lead_byte = 0;
  logic [7:0] rc, key_rc;
  logic ready;

  int n_checks = 0, n_fail = 0, cycles = 0;
  exp_t q[$];
  logic [7:0] tab [12];
  int m_idx;
  logic m_rdy;

  rcon_counter dut (.clk(clk), .rst(rst), .dir_back(dir_back), .step(step),
    .round_done(round_done), .lead_byte(lead_byte), .rc(rc), .key_rc(key_rc), .ready(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic cyc(input logic r, input logic d, input logic s,
                     input logic done, input logic lead, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; dir_back = d; step = s; round_done = done; lead_byte = lead;
    if (r) begin
      m_idx = d ? 10 : 1; m_rdy = 0;
    end else if (!m_rdy) begin
      if (done && m_idx == (d ? 1 : 10)) m_rdy = 1;
      if (s) m_idx = d ? m_idx - 1 : m_idx + 1;
    end
    e.rc = tab[m_idx]; e.key = lead ? tab[m_idx] : 8'h00; e.rdy = m_rdy; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (rc !== e.rc || key_rc !== e.key || ready !== e.rdy) begin
          n_fail++;
          $display("FAIL %s: actual rc=%h key=%h rdy=%b, expected rc=%h key=%h rdy=%b",
                   e.tag, rc, key_rc, ready, e.rc, e.key, e.rdy);
        end
      end
    end
  end

  initial begin
    tab[0] = 8'h8D; tab[1] = 8'h01; tab[2] = 8'h02; tab[3] = 8'h04;
    tab[4] = 8'h08; tab[5] = 8'h10; tab[6] = 8'h20; tab[7] = 8'h40;
    tab[8] = 8'h80; tab[9] = 8'h1B; tab[10] = 8'h36; tab[11] = 8'h6C;
    m_idx = 1; m_rdy = 0;

    cyc(1, 0, 0, 0, 1, "R1 forward reset");
    cyc(0, 0, 0, 0, 1, "R5 hold");
    cyc(0, 0, 0, 0, 0, "R6 gated off");
    for (int i = 0; i < 9; i++) begin
      cyc(0, 0, 1, 0, i[0], "R3 forward walk");
      cyc(0, 0, 0, (i == 4), 1, "R7 early round_done ignored");
    end
    cyc(0, 0, 0, 1, 1, "R7 ready at 0x36");
    cyc(0, 0, 1, 0, 1, "R8 step ignored");
    cyc(0, 0, 1, 1, 0, "R8 sticky");

    cyc(1, 1, 0, 0, 1, "R2 backward reset");
    for (int i = 0; i < 9; i++) begin
      cyc(0, 1, 1, 0, 1, "R4 backward walk");
      cyc(0, 1, 0, (i == 2), 1, "R7 early round_done ignored");
    end
    cyc(0, 1, 0, 1, 1, "R7 ready at 0x01");
    cyc(0, 1, 1, 0, 1, "R8 step ignored");

    cyc(1, 0, 0, 0, 1, "R1 reset clears ready");
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0, 1, "R3 walk past end");
    cyc(0, 0, 0, 1, 1, "R7 no ready at 0x6C");

    cyc(1, 1, 0, 0, 1, "R2 reset");
    for (int i = 0; i < 10; i++) cyc(0, 1, 1, 0, 1, "R4 walk past end");
    cyc(0, 1, 0, 1, 0, "R7 no ready at 0x8D");

    cyc(0, 1, 0, 0, 0, "R5 final hold");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule